// File: doc/BRIEF.md
# Dual-Bank Simultaneous Acquisition Sequencer

This block sequences a sixteen-input analog front end that is organised as two banks of eight channels. Each bank is captured by eight converters working in parallel, so one request to the converter yields eight results at once. An acquisition is started by software, by a falling edge on an external active-low trigger, or by a programmable interval timer. Each acquisition converts the enabled banks, the low bank before the high bank, and pushes the results of the enabled channels into an on-chip sample FIFO. The FIFO is read through a small register port, and it raises an interrupt at a programmable fill level or when it is full.

The converters are outside the block. The block sends a start pulse and a bank number. It then waits for a done pulse that carries all eight results of that bank, each packed into a fixed lane of the data bus. The block captures the eight results into a holding register and starts the next bank in the following cycle. The held results drain into the FIFO, one per cycle, while that second bank converts. When enabled, the block can also send a fixed-width low pulse on a trigger output each time an acquisition starts.

The register map is as follows.
- 0 holds the configuration.
- 1 holds the timer period.
- 2 holds the threshold.
- 3 is status, read only.
- 4 is the command register, write only.
- 5 is the FIFO level.
- 6 is the FIFO data; a read pops one sample.
- 7 holds the interrupt enables.

Top module: `dual_bank_acq_seq`

## Requirements
- R1: After reset, status (address 3) reads 0x0002, which means only the empty bit [1] is set. The level reads 0, `irq` is 0, `trig_out_n` is 1 and `cnv_start` is 0.
- R2: When both banks are enabled, the low bank (`cnv_bank`=0) converts first. The high bank's `cnv_start` is issued in the cycle right after the low bank's `cnv_done`, before the low bank's results have drained.
- R3: Within a bank, samples are pushed in ascending channel order. Channel c is taken from `cnv_data[c*SAMPLE_W +: SAMPLE_W]`, and a channel is pushed only if its bit in config[15:8] is set.
- R4: Config[1:0] selects the banks: bit0 is the low bank and bit1 the high bank. The value 0 starts nothing.
- R5: Reading address 6 returns the oldest sample, sign-extended to 16 bits, and removes it. Reading it while the FIFO is empty returns 0.
- R6: When config[3:2]=0, writing command bit0 starts an acquisition. Status bit0 (busy) stays high until the last sample is pushed.
- R7: When config[3:2]=1, an acquisition starts on a falling edge of `ext_trig_n`. A steady level or a rising edge starts nothing, and command bit0 is ignored.
- R8: When config[3:2]=2, the timer starts an acquisition every period+1 cycles if config[4]=1. If config[4]=0, it starts exactly one acquisition, period cycles after the configuration write.
- R9: When config[5]=1, each accepted start drives `trig_out_n` low for exactly PULSE_CYCLES cycles, and `trig_oe` follows config[5]. When config[5]=0, the pin stays high.
- R10: A start that arrives while busy is ignored and sets the sticky overrun flag, status bit4.
- R11: A sample pushed into a full FIFO is dropped and sets the sticky overflow flag, status bit5. The level and the stored samples are unchanged, and status bit3 reports full.
- R12: `irq` = (enable bit0 AND level >= threshold) OR (enable bit1 AND full). Status bit2 reports level >= threshold.
- R13: Command bit1 clears both sticky flags, and command bit2 empties the FIFO.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (pops on address 6) |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data, combinational from address |
| ext_trig_n | input | 1 | External trigger, active low, asynchronous |
| trig_out_n | output | 1 | Trigger output pulse, active low |
| trig_oe | output | 1 | Trigger output enable |
| cnv_start | output | 1 | One-cycle bank conversion request |
| cnv_bank | output | 1 | Bank being converted (0 low, 1 high) |
| cnv_done | input | 1 | Converter results valid, one cycle |
| cnv_data | input | 8*SAMPLE_W | Eight results, channel c in lane c |
| irq | output | 1 | Level interrupt |

## Verification
A bad bank pointer or a bad drain index shows up at the data port as a sample from the wrong lane or in the wrong order. It appears on the first read after the affected acquisition, because every expected value is unique to one conversion and one channel. A wrong busy or overrun state shows up at the converter interface as a missing or extra `cnv_start`, within a few cycles of the start. A timer that is off by a count shows up as a start interval that differs from period+1 on the second tick. A wrong FIFO level shows up at once in the level register and at `irq` as the threshold is crossed.

// File: rtl/dual_bank_acq_seq.sv
module dual_bank_acq_seq #(
  parameter int SAMPLE_W     = 12,
  parameter int FIFO_DEPTH   = 512,
  parameter int TMR_W        = 16,
  parameter int PULSE_CYCLES = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  reg_wr,
  input  logic                  reg_rd,
  input  logic [2:0]            reg_addr,
  input  logic [15:0]           reg_wdata,
  output logic [15:0]           reg_rdata,
  input  logic                  ext_trig_n,
  output logic                  trig_out_n,
  output logic                  trig_oe,
  output logic                  cnv_start,
  output logic                  cnv_bank,
  input  logic                  cnv_done,
  input  logic [8*SAMPLE_W-1:0] cnv_data,
  output logic                  irq
);
  localparam int CHANS = 8;
  localparam int IW    = $clog2(CHANS);
  localparam int AW    = $clog2(FIFO_DEPTH);
  localparam int CW    = AW + 1;
  localparam int PW    = $clog2(PULSE_CYCLES + 1);

  logic [15:0]      cfg_q, thr_q, ien_q;
  logic [TMR_W-1:0] period_q, tmr_cnt;
  logic             tmr_on;
  logic [2:0]       ext_sync;
  logic             conv_busy, cur_bank, drain_act;
  logic [IW-1:0]    drain_idx;
  logic [CHANS*SAMPLE_W-1:0] hold_q;
  logic [PW-1:0]    pulse_cnt;
  logic             ovr_q, ofl_q;
  logic [SAMPLE_W-1:0] mem [FIFO_DEPTH];
  logic [AW-1:0]    wr_ptr, rd_ptr;
  logic [CW-1:0]    cnt;

  wire [1:0] bank_en   = cfg_q[1:0];
  wire [1:0] trig_src  = cfg_q[3:2];
  wire       cont      = cfg_q[4];
  wire       tout_en   = cfg_q[5];
  wire [7:0] chan_mask = cfg_q[15:8];

  wire cfg_wr  = reg_wr && reg_addr == 3'd0;
  wire cmd_wr  = reg_wr && reg_addr == 3'd4;
  wire sw_go   = cmd_wr && reg_wdata[0];
  wire clr_stk = cmd_wr && reg_wdata[1];
  wire flush   = cmd_wr && reg_wdata[2];

  wire tick     = tmr_on && tmr_cnt == '0;
  wire ext_fall = ext_sync[2] && !ext_sync[1];
  wire start_evt = (trig_src == 2'd0 && sw_go) ||
                   (trig_src == 2'd1 && ext_fall) ||
                   (trig_src == 2'd2 && tick);
  wire busy    = conv_busy || drain_act;
  wire accept  = start_evt && !busy && bank_en != 2'b00;
  wire capture = conv_busy && cnv_done;

  wire full  = cnt == CW'(FIFO_DEPTH);
  wire empty = cnt == '0;
  wire push  = drain_act && chan_mask[drain_idx];
  wire pop   = reg_rd && reg_addr == 3'd6 && !empty;
  wire wr_en = push && !full;
  wire thr_hit = 16'(cnt) >= thr_q;
  wire [SAMPLE_W-1:0] push_data = hold_q[drain_idx*SAMPLE_W +: SAMPLE_W];

  assign cnv_bank   = cur_bank;
  assign trig_out_n = pulse_cnt == '0;
  assign trig_oe    = tout_en;
  assign irq        = (ien_q[0] && thr_hit) || (ien_q[1] && full);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q    <= '0;
      period_q <= '0;
      thr_q    <= 16'(FIFO_DEPTH);
      ien_q    <= '0;
    end else if (reg_wr) begin
      case (reg_addr)
        3'd0: cfg_q    <= reg_wdata;
        3'd1: period_q <= TMR_W'(reg_wdata);
        3'd2: thr_q    <= reg_wdata;
        3'd7: ien_q    <= reg_wdata;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tmr_on  <= 1'b0;
      tmr_cnt <= '0;
    end else if (cfg_wr) begin
      tmr_on  <= reg_wdata[3:2] == 2'd2;
      tmr_cnt <= period_q;
    end else if (tick) begin
      tmr_cnt <= period_q;
      tmr_on  <= cont;
    end else if (tmr_on) begin
      tmr_cnt <= tmr_cnt - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ext_sync <= 3'b111;
    else        ext_sync <= {ext_sync[1:0], ext_trig_n};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      conv_busy <= 1'b0;
      cur_bank  <= 1'b0;
      cnv_start <= 1'b0;
      hold_q    <= '0;
    end else begin
      cnv_start <= 1'b0;
      if (accept) begin
        conv_busy <= 1'b1;
        cur_bank  <= !bank_en[0];
        cnv_start <= 1'b1;
      end else if (capture) begin
        hold_q <= cnv_data;
        if (!cur_bank && bank_en[1]) begin
          cur_bank  <= 1'b1;
          cnv_start <= 1'b1;
        end else begin
          conv_busy <= 1'b0;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      drain_act <= 1'b0;
      drain_idx <= '0;
    end else if (capture) begin
      drain_act <= 1'b1;
      drain_idx <= '0;
    end else if (drain_act) begin
      drain_idx <= drain_idx + 1'b1;
      if (drain_idx == IW'(CHANS - 1)) drain_act <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 pulse_cnt <= '0;
    else if (accept && tout_en) pulse_cnt <= PW'(PULSE_CYCLES);
    else if (pulse_cnt != '0)   pulse_cnt <= pulse_cnt - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovr_q <= 1'b0;
      ofl_q <= 1'b0;
    end else begin
      ovr_q <= (ovr_q && !clr_stk) || (start_evt && busy);
      ofl_q <= (ofl_q && !clr_stk) || (push && full);
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt    <= '0;
    end else if (flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt    <= '0;
    end else begin
      if (wr_en) wr_ptr <= wr_ptr + 1'b1;
      if (pop)   rd_ptr <= rd_ptr + 1'b1;
      cnt <= cnt + CW'(wr_en) - CW'(pop);
    end
  end

  always_comb begin
    case (reg_addr)
      3'd0: reg_rdata = cfg_q;
      3'd1: reg_rdata = 16'(period_q);
      3'd2: reg_rdata = thr_q;
      3'd3: reg_rdata = {10'd0, ofl_q, ovr_q, full, thr_hit, empty, busy};
      3'd5: reg_rdata = 16'(cnt);
      3'd6: reg_rdata = empty ? 16'd0 : 16'($signed(mem[rd_ptr]));
      3'd7: reg_rdata = ien_q;
      default: reg_rdata = 16'd0;
    endcase
  end

  AST_SECOND_BANK: assert property (@(posedge clk) disable iff (!rst_n)
    (capture && !cur_bank && bank_en == 2'b11) |=> (cnv_start && cnv_bank)); // R2
  AST_DRAIN_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    capture |-> !drain_act); // R3
  AST_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    cnv_start |-> conv_busy); // R6
  AST_PULSE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && tout_en) |=> !trig_out_n); // R9
  AST_OVERRUN: assert property (@(posedge clk) disable iff (!rst_n)
    (start_evt && busy) |=> ovr_q); // R10
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(FIFO_DEPTH)); // R11
  AST_FULL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !pop && !flush) |=> (full && $stable(wr_ptr))); // R11
endmodule

// File: tb/dual_bank_acq_seq_test.sv
module dual_bank_acq_seq_test;
  localparam int W = 12;
  localparam int DEPTH = 32;
  localparam int LAT = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_wr = 1'b0, reg_rd = 1'b0;
  logic [2:0] reg_addr = '0;
  logic [15:0] reg_wdata = '0, reg_rdata;
  logic ext_trig_n = 1'b1, trig_out_n, trig_oe;
  logic cnv_start, cnv_bank, cnv_done = 1'b0, irq;
  logic [8*W-1:0] cnv_data = '0;

  dual_bank_acq_seq #(.SAMPLE_W(W), .FIFO_DEPTH(DEPTH), .TMR_W(16), .PULSE_CYCLES(4)) uut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ext_trig_n(ext_trig_n),
    .trig_out_n(trig_out_n), .trig_oe(trig_oe), .cnv_start(cnv_start), .cnv_bank(cnv_bank),
    .cnv_done(cnv_done), .cnv_data(cnv_data), .irq(irq));

  always #2 clk = ~clk;

  int cyc = 0, nconv = 0, cur_k = 0, cd_cnt = 0, lowcnt = 0;
  int nchk = 0, nfail = 0;
  bit finished = 0;
  int bank_log [0:255];
  int start_cyc [0:255];
  int done_cyc [0:255];

  function automatic logic [W-1:0] samp(int k, int c);
    return W'((k * 173 + c * 301 + 1500) % 4096);
  endfunction

  function automatic logic [15:0] sx(logic [W-1:0] s);
    return {{(16-W){s[W-1]}}, s};
  endfunction

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (!trig_out_n) lowcnt = lowcnt + 1;
    cnv_done = 1'b0;
    if (cd_cnt > 0) begin
      cd_cnt = cd_cnt - 1;
      if (cd_cnt == 0) begin
        cnv_done = 1'b1;
        for (int c = 0; c < 8; c++) cnv_data[c*W +: W] = samp(cur_k, c);
        done_cyc[cur_k] = cyc;
      end
    end
    if (cnv_start) begin
      bank_log[nconv] = int'(cnv_bank);
      start_cyc[nconv] = cyc;
      cur_k = nconv;
      nconv = nconv + 1;
      cd_cnt = LAT;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] d);
    @(negedge clk);
    reg_addr = a; reg_rd = 1'b1;
    #1 d = reg_rdata;
    @(posedge clk);
    #1 reg_rd = 1'b0;
  endtask

  task automatic wait_idle();
    logic [15:0] s;
    for (int i = 0; i < 3000; i++) begin
      rd(3'd3, s);
      if (!s[0]) return;
    end
    check(0, "R6 busy never cleared", 1, 0);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic drain_check(input int k0, input logic [1:0] be, input logic [7:0] m, input string req);
    logic [15:0] v;
    int k;
    k = k0;
    for (int b = 0; b < 2; b++) begin
      if (be[b]) begin
        for (int c = 0; c < 8; c++) begin
          if (m[c]) begin
            rd(3'd6, v);
            check(v == sx(samp(k, c)), req, v, sx(samp(k, c)));
          end
        end
        k++;
      end
    end
  endtask

  logic [15:0] v;
  logic [7:0] masks [4];
  int k0, exp_n;

  initial begin
    masks[0] = 8'hFF; masks[1] = 8'h01; masks[2] = 8'hA5; masks[3] = 8'h80;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    rd(3'd3, v); check(v == 16'h0002, "R1 status", v, 16'h0002);
    rd(3'd5, v); check(v == 0, "R1 level", v, 0);
    check(irq == 0 && trig_out_n == 1 && cnv_start == 0, "R1 outputs", {irq, trig_out_n, cnv_start}, 3'b010);
    rd(3'd6, v); check(v == 0, "R5 empty read", v, 0);

    for (int be = 1; be < 4; be++) begin
      for (int mi = 0; mi < 4; mi++) begin
        wr(3'd0, {masks[mi], 8'h00} | 16'(be));
        k0 = nconv;
        lowcnt = 0;
        wr(3'd4, 16'h0001);
        wait_idle();
        exp_n = $countones(masks[mi]) * $countones(2'(be));
        rd(3'd5, v); check(int'(v) == exp_n, "R3 R4 level after acquisition", v, exp_n);
        check(nconv - k0 == $countones(2'(be)), "R4 conversions per start", nconv - k0, $countones(2'(be)));
        check(bank_log[k0] == (be == 2 ? 1 : 0), "R2 R4 first bank", bank_log[k0], be == 2 ? 1 : 0);
        if (be == 3) begin
          check(bank_log[k0+1] == 1, "R2 second bank high", bank_log[k0+1], 1);
          check(start_cyc[k0+1] - done_cyc[k0] == 1, "R2 back-to-back start", start_cyc[k0+1] - done_cyc[k0], 1);
        end
        check(lowcnt == 0, "R9 pin idle when disabled", lowcnt, 0);
        drain_check(k0, 2'(be), masks[mi], "R3 R5 sample order/value");
      end
    end

    wr(3'd0, 16'hFF00);
    k0 = nconv;
    wr(3'd4, 16'h0001);
    idle(30);
    check(nconv == k0, "R4 no bank enabled", nconv - k0, 0);

    wr(3'd0, 16'hFF03);
    k0 = nconv;
    wr(3'd4, 16'h0001);
    wr(3'd4, 16'h0001);
    wait_idle();
    rd(3'd3, v); check(v[4] == 1, "R10 overrun sticky", v[4], 1);
    check(nconv - k0 == 2, "R10 extra start ignored", nconv - k0, 2);
    rd(3'd5, v); check(v == 16, "R10 level", v, 16);
    wr(3'd4, 16'h0002);
    rd(3'd3, v); check(v[4] == 0, "R13 sticky clear", v[4], 0);
    wr(3'd4, 16'h0004);
    rd(3'd5, v); check(v == 0, "R13 flush", v, 0);

    wr(3'd0, 16'hFF25);
    check(trig_oe == 1, "R9 output enable", trig_oe, 1);
    k0 = nconv;
    lowcnt = 0;
    wr(3'd4, 16'h0001);
    idle(20);
    check(nconv == k0, "R7 software start ignored", nconv - k0, 0);
    @(negedge clk) ext_trig_n = 1'b0;
    idle(6);
    check(nconv == k0 + 1, "R7 falling edge starts", nconv - k0, 1);
    idle(40);
    @(negedge clk) ext_trig_n = 1'b1;
    idle(20);
    check(nconv == k0 + 1, "R7 level/rising ignored", nconv - k0, 1);
    check(lowcnt == 4, "R9 pulse width", lowcnt, 4);
    rd(3'd5, v); check(v == 8, "R7 level", v, 8);
    drain_check(k0, 2'b01, 8'hFF, "R7 sample values");

    wr(3'd1, 16'd99);
    k0 = nconv;
    wr(3'd0, 16'h0119);
    idle(520);
    wr(3'd0, 16'h0101);
    wait_idle();
    check(nconv - k0 >= 4, "R8 continuous ticks", nconv - k0, 5);
    for (int i = k0 + 1; i < nconv; i++)
      check(start_cyc[i] - start_cyc[i-1] == 100, "R8 tick interval", start_cyc[i] - start_cyc[i-1], 100);
    wr(3'd4, 16'h0004);
    wr(3'd1, 16'd49);
    k0 = nconv;
    wr(3'd0, 16'h0109);
    idle(400);
    check(nconv - k0 == 1, "R8 one-shot", nconv - k0, 1);
    wait_idle();
    wr(3'd4, 16'h0004);

    wr(3'd2, 16'd10);
    wr(3'd7, 16'h0001);
    wr(3'd0, 16'hFF03);
    wr(3'd4, 16'h0001);
    wait_idle();
    check(irq == 1, "R12 threshold irq", irq, 1);
    for (int i = 0; i < 6; i++) rd(3'd6, v);
    rd(3'd5, v); check(v == 10, "R12 level", v, 10);
    check(irq == 1, "R12 irq at threshold", irq, 1);
    rd(3'd6, v);
    rd(3'd3, v); check(v[2] == 0, "R12 below threshold flag", v[2], 0);
    check(irq == 0, "R12 irq below threshold", irq, 0);
    wr(3'd4, 16'h0004);
    wr(3'd7, 16'h0002);
    k0 = nconv;
    wr(3'd4, 16'h0001);
    wait_idle();
    check(irq == 0, "R12 full irq not yet", irq, 0);
    wr(3'd4, 16'h0001);
    wait_idle();
    rd(3'd3, v); check(v[3] == 1 && v[5] == 0, "R11 full no overflow", v, 16'h0008);
    check(irq == 1, "R12 full irq", irq, 1);
    wr(3'd4, 16'h0001);
    wait_idle();
    rd(3'd3, v); check(v[5] == 1, "R11 overflow sticky", v[5], 1);
    rd(3'd5, v); check(v == DEPTH, "R11 level held", v, DEPTH);
    rd(3'd6, v); check(v == sx(samp(k0, 0)), "R11 oldest kept", v, sx(samp(k0, 0)));
    wr(3'd4, 16'h0006);
    rd(3'd3, v); check(v == 16'h0002, "R13 clear and flush", v, 16'h0002);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      nchk++;
      nfail++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end
endmodule